// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex synchronous serial port that moves one byte at a time over a single data line. It also drives the shift clock that an external shift register or peripheral uses. It is timed by a machine cycle of twelve oscillator clocks, arranged as six states S1..S6 of two phases each. The block contains its own machine-cycle phase generator. One bit moves per machine cycle, with the least significant bit first.

A one-cycle write strobe loads a byte and starts a transmission. Transmission completion is found by a marker 1 placed above the byte in a nine-bit shift register, so no bit counter is needed. Reception starts by itself whenever receive is enabled and the receive-done flag is clear. The receive register is preloaded with seven ones and a zero in its top bit. When that zero reaches the bottom position, the next shift completes the byte. The data line is split into an input, an output and an output enable, so that the pad can tri-state it. The output enable is high only while a byte is being sent.

Top module: `sync_shift_port`

## Requirements
- R1: Out of reset: sd_oe_o=0, sclk_o=1, tx_done_o=0, rx_done_o=0, rx_data_o=0x00.
- R2: A machine cycle is 12 clocks. Phase index 0 is S1P1 and index 11 is S6P2. The first clock edge after reset release ends phase 0. Exactly one bit moves per machine cycle.
- R3: A write (wr_i=1 at a clock edge during machine cycle m) loads the byte. sd_oe_o rises at phase 0 of cycle m+2, and it stays 0 through the end of cycle m+1.
- R4: While transmitting or receiving, sclk_o is 0 during phases 4..9 (S3..S5) and 1 during phases 10, 11, 0..3. When neither is active, sclk_o stays 1.
- R5: Data goes out least significant bit first. Bit k is on sd_o for all of cycle m+2+k, and the line advances only at the end of phase 11.
- R6: sd_oe_o falls and tx_done_o rises at phase 0 of cycle m+10, after exactly 8 bits. This holds for any byte value, including 0x00 and 0xFF.
- R7: A write clears tx_done_o in the cycle that follows it.
- R8: When rx_en_i=1 and rx_done_o=0 during cycle m, the shift clock runs in cycles m+2..m+9. sd_i is sampled at the end of phase 11 of each of those cycles, and the first sample is bit 0.
- R9: rx_data_o takes the 8 sampled bits and rx_done_o rises at phase 0 of cycle m+10. rx_done_o is still 0 at phase 11 of cycle m+9.
- R10: With rx_en_i=0 no reception starts: sclk_o stays 1 and rx_done_o stays 0.
- R11: While rx_done_o=1, no new reception starts even with rx_en_i=1, and rx_data_o holds its value whatever sd_i does.
- R12: rx_clr_i=1 at an edge clears rx_done_o. If rx_en_i is still 1, a new reception follows with the R8/R9 timing, counted from the cycle of the clear.
- R13: The data line is never driven during a reception (sd_oe_o=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Data register write strobe |
| wr_data_i | input | DATA_W | Byte to transmit |
| rx_en_i | input | 1 | Receive enable |
| rx_clr_i | input | 1 | Clears the receive-done flag |
| sd_i | input | 1 | Data line input from pad |
| sd_o | output | 1 | Data line output to pad |
| sd_oe_o | output | 1 | Data line output enable (1 only while sending) |
| sclk_o | output | 1 | Shift clock |
| rx_data_o | output | DATA_W | Last received byte |
| tx_done_o | output | 1 | Transmit-done flag |
| rx_done_o | output | 1 | Receive-done flag |

## Verification
Every result is due a fixed number of machine cycles after its stimulus. The data line is enabled at phase 0 two cycles after the write, and bit k is held for cycle m+2+k. Both done flags rise at phase 0 of cycle m+10, and received bits are taken at phase 11 of cycles m+2..m+9. The bench keeps its own phase and cycle counters from reset release and samples outputs on falling clock edges at named phase slots. Each flag is checked both at the last slot before it is due and at the first slot where it is due, so a result one phase early or late is caught.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int unsigned DATA_W_DEF   = 8;
  localparam int unsigned PHASES_DEF   = 12;
  localparam int unsigned LO_FIRST_DEF = 4;
  localparam int unsigned LO_LAST_DEF  = 9;

  typedef enum logic [1:0] {TX_IDLE, TX_WAIT, TX_ARM, TX_SEND} tx_state_e;
  typedef enum logic [1:0] {RX_IDLE, RX_ARMED, RX_LOADED, RX_ACTIVE} rx_state_e;
endpackage

// File: rtl/ssp_phase_gen.sv
module ssp_phase_gen
  import ssp_pkg::*;
#(
  parameter int unsigned PHASES   = PHASES_DEF,
  parameter int unsigned LO_FIRST = LO_FIRST_DEF,
  parameter int unsigned LO_LAST  = LO_LAST_DEF,
  localparam int unsigned PH_W    = $clog2(PHASES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PH_W-1:0] ph_o,
  output logic            last_o,
  output logic            lo_win_o
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ph_q <= '0;
    else if (ph_q == PH_LAST) ph_q <= '0;
    else                    ph_q <= ph_q + PH_W'(1);
  end

  assign ph_o     = ph_q;
  assign last_o   = (ph_q == PH_LAST);
  assign lo_win_o = (ph_q >= PH_W'(LO_FIRST)) && (ph_q <= PH_W'(LO_LAST));
endmodule

// File: rtl/ssp_tx.sv
module ssp_tx
  import ssp_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              last_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              send_o,
  output logic              busy_o,
  output logic              bit_o,
  output logic              done_o
);
  // marker 1 above the byte; once it sits at bit 1 the next shift is the last
  logic [DATA_W:0] sr_q;
  tx_state_e       st_q;
  logic            done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      st_q   <= TX_IDLE;
      done_q <= 1'b0;
    end else if (wr_i) begin
      sr_q   <= {1'b1, wr_data_i};
      st_q   <= last_i ? TX_ARM : TX_WAIT;
      done_q <= 1'b0;
    end else if (last_i) begin
      case (st_q)
        TX_WAIT: st_q <= TX_ARM;
        TX_ARM:  st_q <= TX_SEND;
        TX_SEND: begin
          sr_q <= {1'b0, sr_q[DATA_W:1]};
          if (sr_q[DATA_W:1] == DATA_W'(1)) begin
            st_q   <= TX_IDLE;
            done_q <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign send_o = (st_q == TX_SEND);
  assign busy_o = (st_q != TX_IDLE);
  assign bit_o  = sr_q[0];
  assign done_o = done_q;
endmodule

// File: rtl/ssp_rx.sv
module ssp_rx
  import ssp_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              last_i,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic              hold_i,
  input  logic              sd_i,
  output logic              active_o,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o
);
  // preload: zero on top, ones below; the zero reaching bit 0 flags the final shift
  localparam logic [DATA_W-1:0] PRELOAD = {1'b0, {(DATA_W-1){1'b1}}};

  logic [DATA_W-1:0] sr_q, buf_q;
  rx_state_e         st_q;
  logic              done_q;
  logic              start;

  assign start = en_i && !done_q && !hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      buf_q  <= '0;
      st_q   <= RX_IDLE;
      done_q <= 1'b0;
    end else begin
      if (clr_i) done_q <= 1'b0;
      case (st_q)
        RX_IDLE:   if (last_i && start) st_q <= RX_ARMED;
        RX_ARMED:  if (last_i) begin
          sr_q <= PRELOAD;
          st_q <= RX_LOADED;
        end
        RX_LOADED: st_q <= RX_ACTIVE;
        RX_ACTIVE: if (last_i) begin
          if (!sr_q[0]) begin
            buf_q  <= {sd_i, sr_q[DATA_W-1:1]};
            done_q <= 1'b1;
            st_q   <= RX_IDLE;
          end else begin
            sr_q <= {sd_i, sr_q[DATA_W-1:1]};
          end
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  assign active_o = (st_q == RX_ACTIVE);
  assign data_o   = buf_q;
  assign done_o   = done_q;
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
  import ssp_pkg::*;
#(
  parameter int unsigned DATA_W        = DATA_W_DEF,
  parameter int unsigned PHASES        = PHASES_DEF,
  parameter int unsigned SCLK_LO_FIRST = LO_FIRST_DEF,
  parameter int unsigned SCLK_LO_LAST  = LO_LAST_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rx_en_i,
  input  logic              rx_clr_i,
  input  logic              sd_i,
  output logic              sd_o,
  output logic              sd_oe_o,
  output logic              sclk_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              tx_done_o,
  output logic              rx_done_o
);
  localparam int unsigned PH_W         = $clog2(PHASES);
  localparam int unsigned SCLK_RISE_PH = (SCLK_LO_LAST + 1) % PHASES;

  logic [PH_W-1:0] ph;
  logic            last, lo_win;
  logic            send, tx_busy, tx_bit, rx_active;

  ssp_phase_gen #(
    .PHASES  (PHASES),
    .LO_FIRST(SCLK_LO_FIRST),
    .LO_LAST (SCLK_LO_LAST)
  ) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ph_o    (ph),
    .last_o  (last),
    .lo_win_o(lo_win)
  );

  ssp_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .last_i   (last),
    .wr_i     (wr_i),
    .wr_data_i(wr_data_i),
    .send_o   (send),
    .busy_o   (tx_busy),
    .bit_o    (tx_bit),
    .done_o   (tx_done_o)
  );

  ssp_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .last_i  (last),
    .en_i    (rx_en_i),
    .clr_i   (rx_clr_i),
    .hold_i  (tx_busy),
    .sd_i    (sd_i),
    .active_o(rx_active),
    .data_o  (rx_data_o),
    .done_o  (rx_done_o)
  );

  assign sd_oe_o = send;
  assign sd_o    = send ? tx_bit : 1'b1;
  assign sclk_o  = !((send || rx_active) && lo_win);
endmodule

// File: rtl/ssp_chk.sv
module ssp_chk #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned PH_W     = 4,
  parameter int unsigned LO_FIRST = 4,
  parameter int unsigned RISE_PH  = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [PH_W-1:0]   ph_i,
  input logic              rx_active_i,
  input logic              dat_i,
  input logic              dat_oe_i,
  input logic              sclk_i,
  input logic [DATA_W-1:0] rx_data_i,
  input logic              tx_done_i,
  input logic              rx_done_i
);
  AST_SCLK_FALL_PH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_i) |-> ph_i == PH_W'(LO_FIRST)); // R4
  AST_SCLK_RISE_PH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_i) |-> ph_i == PH_W'(RISE_PH)); // R4
  AST_OE_RISE_PH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dat_oe_i) |-> ph_i == '0); // R3
  AST_BIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_oe_i && $past(dat_oe_i) && ph_i != '0) |-> $stable(dat_i)); // R5
  AST_TX_DONE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_done_i) |-> $fell(dat_oe_i)); // R6
  AST_RX_DONE_PH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_done_i) |-> ph_i == '0); // R9
  AST_RX_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_active_i |-> !dat_oe_i); // R13
  AST_RX_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && $past(rx_done_i)) |-> $stable(rx_data_i)); // R11
endmodule

bind sync_shift_port ssp_chk #(
  .DATA_W  (DATA_W),
  .PH_W    (PH_W),
  .LO_FIRST(SCLK_LO_FIRST),
  .RISE_PH (SCLK_RISE_PH)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ph_i       (ph),
  .rx_active_i(rx_active),
  .dat_i      (sd_o),
  .dat_oe_i   (sd_oe_o),
  .sclk_i     (sclk_o),
  .rx_data_i  (rx_data_o),
  .tx_done_i  (tx_done_o),
  .rx_done_i  (rx_done_o)
);

// File: tb/sync_shift_port_tb_top.sv
module sync_shift_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rx_en = 1'b0;
  logic       rx_clr = 1'b0;
  logic       sd_in = 1'b1;
  logic       sd_out, sd_oe, sclk;
  logic [7:0] rx_data;
  logic       tx_done, rx_done;

  int n_chk = 0;
  int n_fail = 0;
  int ph = 0;
  int mc = 0;

  sync_shift_port dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .wr_i     (wr),
    .wr_data_i(wr_data),
    .rx_en_i  (rx_en),
    .rx_clr_i (rx_clr),
    .sd_i     (sd_in),
    .sd_o     (sd_out),
    .sd_oe_o  (sd_oe),
    .sclk_o   (sclk),
    .rx_data_o(rx_data),
    .tx_done_o(tx_done),
    .rx_done_o(rx_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // independent phase/cycle model (R2)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= 0;
      mc <= 0;
    end else if (ph == 11) begin
      ph <= 0;
      mc <= mc + 1;
    end else begin
      ph <= ph + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=0x%0h exp=0x%0h (cycle %0d phase %0d)", req, act, exp, mc, ph);
    end
  endtask

  task automatic wait_at(input int c, input int p);
    while (!(mc == c && ph == p)) @(negedge clk);
  endtask

  task automatic align(input int p);
    @(negedge clk);
    while (ph != p) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 oe", 32'(sd_oe), 0);
    check("R1 sclk", 32'(sclk), 1);
    check("R1 tx_done", 32'(tx_done), 0);
    check("R1 rx_done", 32'(rx_done), 0);
    check("R1 rx_data", 32'(rx_data), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_tx(input logic [7:0] d);
    int m;
    align(3);
    m = mc;
    wr = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr = 1'b0;
    check("R7 tx_done cleared by write", 32'(tx_done), 0);
    wait_at(m + 1, 11);
    check("R3 oe low before start", 32'(sd_oe), 0);
    check("R4 sclk idle high", 32'(sclk), 1);
    for (int k = 0; k < 8; k++) begin
      wait_at(m + 2 + k, 1);
      check("R3 oe during send", 32'(sd_oe), 1);
      check("R5 bit early in cycle", 32'(sd_out), 32'(d[k]));
      check("R2/R4 sclk high phase 1", 32'(sclk), 1);
      wait_at(m + 2 + k, 6);
      check("R2/R4 sclk low phase 6", 32'(sclk), 0);
      wait_at(m + 2 + k, 11);
      check("R5 bit held to phase 11", 32'(sd_out), 32'(d[k]));
      check("R4 sclk high phase 11", 32'(sclk), 1);
      check("R6 tx_done not early", 32'(tx_done), 0);
    end
    wait_at(m + 10, 0);
    check("R6 oe released", 32'(sd_oe), 0);
    check("R6 tx_done set", 32'(tx_done), 1);
    wait_at(m + 10, 6);
    check("R4 sclk high after send", 32'(sclk), 1);
  endtask

  task automatic t_rx_disabled();
    int m;
    rx_en = 1'b0;
    align(0);
    m = mc;
    for (int k = 0; k < 4; k++) begin
      sd_in = k[0];
      wait_at(m + k, 6);
      check("R10 sclk stays high without enable", 32'(sclk), 1);
      check("R10 rx_done stays low", 32'(rx_done), 0);
    end
  endtask

  // use_clr=0: start by raising enable; use_clr=1: start by clearing the flag (R12)
  task automatic t_rx(input logic [7:0] d, input bit use_clr);
    int m;
    align(5);
    m = mc;
    if (use_clr) begin
      check("R12 rx_done set before clear", 32'(rx_done), 1);
      rx_clr = 1'b1;
      @(negedge clk);
      rx_clr = 1'b0;
      check("R12 rx_done cleared", 32'(rx_done), 0);
    end else begin
      rx_en = 1'b1;
    end
    wait_at(m + 1, 6);
    check("R8 no shift clock before start", 32'(sclk), 1);
    for (int k = 0; k < 8; k++) begin
      wait_at(m + 2 + k, 1);
      sd_in = d[k];
      wait_at(m + 2 + k, 6);
      check("R8 sclk low during receive", 32'(sclk), 0);
      check("R13 line not driven", 32'(sd_oe), 0);
    end
    wait_at(m + 9, 11);
    check("R9 rx_done not early", 32'(rx_done), 0);
    wait_at(m + 10, 0);
    check(use_clr ? "R12 rx_done again" : "R9 rx_done set", 32'(rx_done), 1);
    check(use_clr ? "R12 rx_data again" : "R9 rx_data", 32'(rx_data), 32'(d));
  endtask

  task automatic t_rx_blocked(input logic [7:0] held);
    int m;
    align(0);
    m = mc;
    for (int k = 0; k < 12; k++) begin
      wait_at(m + k, 2);
      sd_in = ~sd_in;
      wait_at(m + k, 6);
      check("R11 no shift clock while flag set", 32'(sclk), 1);
      check("R11 rx_data held", 32'(rx_data), 32'(held));
    end
    check("R11 rx_done still set", 32'(rx_done), 1);
  endtask

  initial begin
    t_reset();
    t_tx(8'hA5);
    t_tx(8'h00);
    t_tx(8'hFF);
    t_tx(8'h01);
    t_rx_disabled();
    t_rx(8'h3C, 1'b0);
    t_rx_blocked(8'h3C);
    t_rx(8'hC3, 1'b1);
    t_rx(8'h80, 1'b1);
    rx_en = 1'b0;
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired (cycle %0d phase %0d)", mc, ph);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule